// File: doc/BRIEF.md
# Shared-Timer Input Debouncer

This block filters the already-synchronized inputs of a 32-pin bank before they reach the data and interrupt logic. Three global period registers each hold a stability time, counted in clock cycles. Every pin picks one of these periods, or none, through a 2-bit code. The code's two bits sit at the pin's bit position in two separate selection registers. A debounced pin's filtered output takes a new level only after the raw input has kept that level for at least the chosen number of cycles.

Software converts time to cycles and decides which pins share which period. The hardware only applies the programmed values. Registers are written and read over a simple single-cycle register bus. Reads are combinational from the address. A debounced pin keeps its own stability counter. A change to its selection code, or a write to the period register it uses, starts its count again from zero.

Top module: `dbn_bank`

## Requirements
- R1: After reset, all five registers read 0, every pin is in bypass, and `pin_filt` equals `pin_raw`.
- R2: The register map uses byte addresses. 0x00 is the high-code-bit register and 0x04 is the low-code-bit register. 0x08, 0x0C and 0x10 are the periods for codes 1, 2 and 3. A write stores `bus_wdata` and the value reads back. Any other address reads 0, and a write to it changes no register.
- R3: A pin whose code is 0 is in bypass: `pin_filt[i]` equals `pin_raw[i]` in the same cycle, with no register delay.
- R4: Pin i's code is {high register bit i, low register bit i}. Code k (1..3) uses period register k. Pins with different codes filter independently and at the same time.
- R5: With period P > 0, let a new raw level be first sampled at clock edge 0 and held. The filtered output then changes right after edge P and stays unchanged before that edge.
- R6: If the raw input goes back to the filtered level before edge P, the filtered output never changes.
- R7: A pin whose selected period register holds 0 behaves as in bypass (R3).
- R8: A restart resets a pin's counter at the write edge W, and a held new level is then accepted right after edge W+P+1. A restart is caused by a write that changes either of the pin's code bits, or by any write to the period register the pin selects, even with the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_raw | input | 32 | Synchronized pin inputs |
| pin_filt | output | 32 | Filtered pin outputs |

## Verification
In bypass, the output follows the input combinationally, so the bench checks it one time step after driving an input at the falling edge. For a debounced pin, the bench changes the input just before rising edge 0. After each falling edge that follows rising edge e, it expects the new level exactly when e ≥ P. This places the first changed sample right after edge P. For restarts, the bench counts rising edges from the write edge W and expects the change only after edge W+P+1. Register reads are checked one time step after the address is applied.

// File: rtl/dbn_pkg.sv
`timescale 1ns/1ps
package dbn_pkg;
  // Word indices (byte address / 4) of the registers
  localparam logic [2:0] W_SEL_HI = 3'd0;
  localparam logic [2:0] W_SEL_LO = 3'd1;
  localparam logic [2:0] W_PER1   = 3'd2;
  localparam logic [2:0] W_PER2   = 3'd3;
  localparam logic [2:0] W_PER3   = 3'd4;
  localparam int NUM_PERIODS = 3;
  typedef logic [1:0] sel_code_t;
endpackage

// File: rtl/dbn_regs.sv
`timescale 1ns/1ps
module dbn_regs
  import dbn_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_sel,
  input  logic                                  bus_wr,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [31:0]                           bus_wdata,
  output logic [31:0]                           bus_rdata,
  output logic [NPINS-1:0]                      sel_hi,
  output logic [NPINS-1:0]                      sel_lo,
  output logic [NUM_PERIODS-1:0][CNT_W-1:0]     periods,
  output logic [NPINS-1:0]                      restart
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_any, wr_hi, wr_lo;
  logic [NUM_PERIODS-1:0] wr_per;
  logic              mapped;

  logic [NPINS-1:0] sel_hi_q, sel_hi_d, sel_lo_q, sel_lo_d;
  logic [NUM_PERIODS-1:0][CNT_W-1:0] per_q, per_d;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign mapped  = aligned && (word <= WORD_W'(W_PER3));
  assign wr_any  = bus_sel && bus_wr && aligned;
  assign wr_hi   = wr_any && (word == WORD_W'(W_SEL_HI));
  assign wr_lo   = wr_any && (word == WORD_W'(W_SEL_LO));

  generate
    for (genvar k = 0; k < NUM_PERIODS; k++) begin : g_wper
      assign wr_per[k] = wr_any && (word == WORD_W'(W_PER1) + WORD_W'(k));
    end
  endgenerate

  // Next-state
  always_comb begin
    sel_hi_d = wr_hi ? bus_wdata[NPINS-1:0] : sel_hi_q;
    sel_lo_d = wr_lo ? bus_wdata[NPINS-1:0] : sel_lo_q;
    per_d    = per_q;
    for (int k = 0; k < NUM_PERIODS; k++) begin
      if (wr_per[k]) per_d[k] = bus_wdata[CNT_W-1:0];
    end
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_q <= '0;
      sel_lo_q <= '0;
      per_q    <= '0;
    end else begin
      if (wr_hi) sel_hi_q <= sel_hi_d;
      if (wr_lo) sel_lo_q <= sel_lo_d;
      if (|wr_per) per_q  <= per_d;
    end
  end

  // Per-pin restart: a code bit flips, or the selected period is written
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      restart[i] = (wr_hi && (bus_wdata[i] != sel_hi_q[i])) ||
                   (wr_lo && (bus_wdata[i] != sel_lo_q[i]));
      for (int k = 0; k < NUM_PERIODS; k++) begin
        if (wr_per[k] && ({sel_hi_q[i], sel_lo_q[i]} == sel_code_t'(k + 1)))
          restart[i] = 1'b1;
      end
    end
  end

  // Combinational read
  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      unique case (word)
        WORD_W'(W_SEL_HI): bus_rdata = 32'(sel_hi_q);
        WORD_W'(W_SEL_LO): bus_rdata = 32'(sel_lo_q);
        WORD_W'(W_PER1):   bus_rdata = 32'(per_q[0]);
        WORD_W'(W_PER2):   bus_rdata = 32'(per_q[1]);
        default:           bus_rdata = 32'(per_q[2]);
      endcase
    end
  end

  assign sel_hi  = sel_hi_q;
  assign sel_lo  = sel_lo_q;
  assign periods = per_q;

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !mapped) |=> ($stable(sel_hi_q) && $stable(sel_lo_q) && $stable(per_q))); // R2
endmodule

// File: rtl/dbn_pin.sv
`timescale 1ns/1ps
module dbn_pin
  import dbn_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              raw,
  input  sel_code_t                         code,
  input  logic [NUM_PERIODS-1:0][CNT_W-1:0] periods,
  input  logic                              restart,
  output logic                              filt
);
  logic [CNT_W-1:0] period;
  logic             bypass;
  logic             prev_q, filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             filt_en;

  assign period = (code == 2'd0) ? '0 : periods[code - 2'd1];
  assign bypass = (period == '0);

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (bypass) begin
      filt_d = raw;
      cnt_d  = '0;
    end else if (restart) begin
      cnt_d  = '0;
    end else if (raw == filt_q) begin
      cnt_d  = '0;
    end else if (raw != prev_q) begin
      cnt_d  = CNT_W'(1);
    end else if (cnt_q >= period) begin
      filt_d = raw;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  assign filt_en = (filt_d != filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= raw;
      cnt_q  <= cnt_d;
      if (filt_en) filt_q <= filt_d;
    end
  end

  assign filt = bypass ? raw : filt_q;

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> (cnt_q <= period)); // R5
  AST_CHANGING_INPUT_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (raw != prev_q)) |=> (filt_q == $past(filt_q))); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R8
  AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (filt_q == $past(raw))); // R7
endmodule

// File: rtl/dbn_bank.sv
`timescale 1ns/1ps
module dbn_bank
  import dbn_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_raw,
  output logic [NPINS-1:0]  pin_filt
);
  logic [NPINS-1:0] sel_hi, sel_lo, restart;
  logic [NUM_PERIODS-1:0][CNT_W-1:0] periods;

  dbn_regs #(.NPINS(NPINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel_hi    (sel_hi),
    .sel_lo    (sel_lo),
    .periods   (periods),
    .restart   (restart)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      dbn_pin #(.CNT_W(CNT_W)) i_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (pin_raw[i]),
        .code    ({sel_hi[i], sel_lo[i]}),
        .periods (periods),
        .restart (restart[i]),
        .filt    (pin_filt[i])
      );
    end
  endgenerate

  AST_BYPASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_hi[0] && !sel_lo[0]) |-> (pin_filt[0] == pin_raw[0])); // R3
endmodule

// File: tb/test_dbn_bank.sv
`timescale 1ns/1ps
module test_dbn_bank;
  localparam int NP = 32;
  localparam int CW = 32;
  localparam int AW = 5;

  logic          clk, rst_n, bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pin_raw, pin_filt;
  int n_run = 0;
  int n_fail = 0;

  dbn_bank #(.NPINS(NP), .CNT_W(CW), .ADDR_W(AW)) i_dbn_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      bus_read(AW'(a * 4), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset output", 32'(pin_filt), 32'(pin_raw));
  endtask

  task automatic t_map();
    logic [31:0] v;
    bus_write(5'h00, 32'hA5A5_0F0F);
    bus_write(5'h04, 32'h1234_5678);
    bus_write(5'h08, 32'h0000_0011);
    bus_write(5'h0C, 32'h0000_0022);
    bus_write(5'h10, 32'h0000_0033);
    bus_read(5'h00, v); chk("R2 high code reg", v, 32'hA5A5_0F0F);
    bus_read(5'h04, v); chk("R2 low code reg", v, 32'h1234_5678);
    bus_read(5'h08, v); chk("R2 period 1", v, 32'h11);
    bus_read(5'h0C, v); chk("R2 period 2", v, 32'h22);
    bus_read(5'h10, v); chk("R2 period 3", v, 32'h33);
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_read(5'h14, v); chk("R2 unmapped reads zero", v, 32'h0);
    bus_read(5'h08, v); chk("R2 unmapped write ignored", v, 32'h11);
    for (int a = 0; a < 5; a++) bus_write(AW'(a * 4), 32'h0);
  endtask

  task automatic t_bypass();
    logic [NP-1:0] pats [4] = '{32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h5A5A_C3C3};
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      pin_raw = pats[p];
      #1 chk("R3 bypass same cycle", 32'(pin_filt), 32'(pats[p]));
    end
    @(negedge clk); pin_raw = '0;
    repeat (2) @(negedge clk);
  endtask

  // pin0 code1 P=3, pin1 code2 P=5, pin2 code3 P=8
  task automatic t_debounce();
    bus_write(5'h08, 32'd3);
    bus_write(5'h0C, 32'd5);
    bus_write(5'h10, 32'd8);
    bus_write(5'h00, 32'b110);
    bus_write(5'h04, 32'b101);
    repeat (2) @(negedge clk);
    pin_raw[2:0] = 3'b111;
    pin_raw[9]   = 1'b1;
    #1 chk("R4 other pin bypass", 32'(pin_filt[9]), 32'h1);
    for (int e = 0; e <= 9; e++) begin
      @(negedge clk);
      chk("R5 pin0 P=3", 32'(pin_filt[0]), 32'(e >= 3));
      chk("R4 pin1 P=5", 32'(pin_filt[1]), 32'(e >= 5));
      chk("R4 pin2 P=8", 32'(pin_filt[2]), 32'(e >= 8));
    end
  endtask

  task automatic t_glitch();
    @(negedge clk); pin_raw[1] = 1'b0;
    for (int e = 0; e <= 3; e++) begin
      @(negedge clk);
      chk("R6 glitch held off", 32'(pin_filt[1]), 32'h1);
    end
    pin_raw[1] = 1'b1;
    for (int e = 0; e < 6; e++) begin
      @(negedge clk);
      chk("R6 glitch rejected", 32'(pin_filt[1]), 32'h1);
    end
  endtask

  task automatic t_zero_period();
    bus_write(5'h10, 32'd0);
    @(negedge clk); pin_raw[2] = 1'b0;
    #1 chk("R7 zero period follows low", 32'(pin_filt[2]), 32'h0);
    @(negedge clk); pin_raw[2] = 1'b1;
    #1 chk("R7 zero period follows high", 32'(pin_filt[2]), 32'h1);
  endtask

  task automatic t_restart();
    @(negedge clk); pin_raw[0] = 1'b0;   // before edge 0
    @(negedge clk);                      // after edge 0
    @(negedge clk);                      // after edge 1
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'd3;
    @(negedge clk);                      // after edge 2 = W
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R8 restart held", 32'(pin_filt[0]), 32'h1);
    for (int e = 3; e <= 5; e++) begin
      @(negedge clk);
      chk("R8 restart held", 32'(pin_filt[0]), 32'h1);
    end
    @(negedge clk);                      // after edge 6 = W+P+1
    chk("R8 accepted after restart", 32'(pin_filt[0]), 32'h0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_bypass();
    t_debounce();
    t_glitch();
    t_zero_period();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule